// File: doc/BRIEF.md
# Reset Sequencer with Millisecond Timebase

This block sits between the board-level reset sources and the register default loader of a CCD timing board. A free-running divider turns the 40 MHz system clock into a one-cycle tick every millisecond. The tick times a power-stable wait after power-up, a board-button reset or the release of a remote reset line. It also debounces the button, and the same tick is brought out so that other logic can time integration periods.

A remote reset level, once synchronized, drives the active-low reset of the downstream timing generator directly. When the level drops, the full delayed initialization runs again. When the wait expires, the block copies the mode switches and the integration-select inputs into holding registers and sends a single start pulse to the loader. Switch changes made at any other time have no effect until the next reset cycle.

Any new reset event during the wait or after the start restarts the wait from zero. A start that is still pending is then abandoned. All pins are plain control levels or pulses, with no handshaking.

Top module: `rst_seq`

## Requirements
- R1: `ms_tick` is high for exactly one cycle out of every CLK_PER_TICK cycles. The first pulse comes in cycle CLK_PER_TICK after power-on reset is released. Only power-on reset affects it; the button and the remote line do not.
- R2: After power-on reset is released, `load_start` is high for exactly one cycle. That cycle directly follows the DELAY_TICKS-th tick counted from the start of the wait.
- R3: `tg_rst_n` is 0 while power-on reset is applied. After that it equals the inverse of `remote_rst` as sampled three clock edges earlier: two synchronizer flops, then an output register.
- R4: When the synchronized remote line falls, the wait restarts from zero. One `load_start` then follows the DELAY_TICKS-th subsequent tick.
- R5: No `load_start` occurs while `tg_rst_n` is 0. A button press while the remote line is held has no effect.
- R6: `mode_q` and `intg_q` load `mode_sw` and `intg_sel` only on the edge that raises `load_start`. At every other time they hold their value, which is zero after power-on.
- R7: A button press counts only if the synchronized button level differs from the debounced level across DEB_TICKS consecutive ticks. A shorter pulse changes nothing.
- R8: A debounced press, in any state other than remote hold, restarts the wait from zero. Any pending start is abandoned, so exactly one `load_start` follows the last press.
- R9: A debounced button release does not restart the wait and produces no `load_start`.
- R10: Each initialization produces at most one `load_start`. The pulse is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (40 MHz nominal) |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| board_btn | input | 1 | Raw board reset button, high when pressed |
| remote_rst | input | 1 | Raw remote reset level, high holds the timing generator in reset |
| mode_sw | input | SW_W | Mode switch inputs |
| intg_sel | input | SEL_W | Integration-time select inputs |
| tg_rst_n | output | 1 | Active-low reset to the timing generator |
| mode_q | output | SW_W | Mode switches captured at the last start |
| intg_q | output | SEL_W | Integration select captured at the last start |
| load_start | output | 1 | One-cycle start pulse to the register default loader |
| ms_tick | output | 1 | Free-running one-cycle millisecond tick |

## Verification
The assertions check several properties on every cycle. The tick spacing must match an independent phase counter. The reset output must follow the remote line with a three-edge latency. The start pulse must be a single cycle and must never appear while the timing generator is held. The captured switch values may change only together with the start pulse and must equal the inputs at that edge.

Some behaviours depend on history and only the bench's scenarios can show them. These are: a wait restarted by a second press partway through, a short button glitch that is rejected, a button release that causes no restart, a press that is ignored during remote hold, and switch changes that are ignored after the start. A cycle-level reference model checks each of them.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    SQ_HOLD  = 2'd0,
    SQ_DELAY = 2'd1,
    SQ_RUN   = 2'd2
  } seq_state_t;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/rsq_tick_div.sv
module rsq_tick_div #(
  parameter int unsigned CLK_PER_TICK = 40000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  import rst_seq_pkg::*;

  localparam int unsigned CW = cnt_width(CLK_PER_TICK);
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (phase == LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + CW'(1);
    end
  end

  assign tick = (phase == LAST);

endmodule

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/rsq_debounce.sv
module rsq_debounce #(
  parameter int unsigned DEB_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic lvl_s,
  output logic press
);

  localparam int unsigned EFF = (DEB_TICKS < 2) ? 2 : DEB_TICKS;
  localparam int unsigned DW  = $clog2(EFF + 1);
  localparam logic [DW-1:0] LAST = DW'(EFF - 1);

  logic          lvl_db;
  logic [DW-1:0] agree_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_db    <= 1'b0;
      agree_cnt <= '0;
      press     <= 1'b0;
    end else begin
      press <= 1'b0;
      if (lvl_s == lvl_db) begin
        agree_cnt <= '0;
      end else if (tick) begin
        if (agree_cnt == LAST) begin
          lvl_db    <= lvl_s;
          agree_cnt <= '0;
          press     <= lvl_s;
        end else begin
          agree_cnt <= agree_cnt + DW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl #(
  parameter int unsigned DELAY_TICKS = 100,
  parameter int unsigned SW_W        = 8,
  parameter int unsigned SEL_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             remote_s,
  input  logic             press,
  input  logic [SW_W-1:0]  mode_sw,
  input  logic [SEL_W-1:0] intg_sel,
  output logic             tg_rst_n,
  output logic             load_start,
  output logic [SW_W-1:0]  mode_q,
  output logic [SEL_W-1:0] intg_q
);
  import rst_seq_pkg::*;

  localparam int unsigned DW = $clog2(DELAY_TICKS + 1);
  localparam logic [DW-1:0] LAST = DW'(DELAY_TICKS - 1);

  seq_state_t    state, state_nx;
  logic [DW-1:0] wait_cnt, wait_cnt_nx;
  logic          fire;

  always_comb begin
    state_nx    = state;
    wait_cnt_nx = wait_cnt;
    fire        = 1'b0;
    if (remote_s) begin
      state_nx    = SQ_HOLD;
      wait_cnt_nx = '0;
    end else if (state == SQ_HOLD || press) begin
      state_nx    = SQ_DELAY;
      wait_cnt_nx = '0;
    end else if (state == SQ_DELAY && tick) begin
      if (wait_cnt == LAST) begin
        state_nx    = SQ_RUN;
        wait_cnt_nx = '0;
        fire        = 1'b1;
      end else begin
        wait_cnt_nx = wait_cnt + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_DELAY;
      wait_cnt   <= '0;
      tg_rst_n   <= 1'b0;
      load_start <= 1'b0;
      mode_q     <= '0;
      intg_q     <= '0;
    end else begin
      state      <= state_nx;
      wait_cnt   <= wait_cnt_nx;
      tg_rst_n   <= !remote_s;
      load_start <= fire;
      if (fire) begin
        mode_q <= mode_sw;
        intg_q <= intg_sel;
      end
    end
  end

endmodule

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int unsigned CLK_PER_TICK = 40000,
  parameter int unsigned DELAY_TICKS  = 100,
  parameter int unsigned DEB_TICKS    = 2,
  parameter int unsigned SW_W         = 8,
  parameter int unsigned SEL_W        = 5
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             board_btn,
  input  logic             remote_rst,
  input  logic [SW_W-1:0]  mode_sw,
  input  logic [SEL_W-1:0] intg_sel,
  output logic             tg_rst_n,
  output logic [SW_W-1:0]  mode_q,
  output logic [SEL_W-1:0] intg_q,
  output logic             load_start,
  output logic             ms_tick
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [1:0] raw_in, sync_out;
  logic       btn_s, remote_s, press;

  assign raw_in   = {board_btn, remote_rst};
  assign btn_s    = sync_out[1];
  assign remote_s = sync_out[0];

  rsq_tick_div #(.CLK_PER_TICK(CLK_PER_TICK)) u_div (
    .clk   (clk),
    .rst_n (por_n),
    .tick  (ms_tick)
  );

  rsq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (raw_in),
    .q     (sync_out)
  );

  rsq_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk   (clk),
    .rst_n (por_n),
    .tick  (ms_tick),
    .lvl_s (btn_s),
    .press (press)
  );

  rsq_ctrl #(
    .DELAY_TICKS (DELAY_TICKS),
    .SW_W        (SW_W),
    .SEL_W       (SEL_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (por_n),
    .tick       (ms_tick),
    .remote_s   (remote_s),
    .press      (press),
    .mode_sw    (mode_sw),
    .intg_sel   (intg_sel),
    .tg_rst_n   (tg_rst_n),
    .load_start (load_start),
    .mode_q     (mode_q),
    .intg_q     (intg_q)
  );

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int unsigned CLK_PER_TICK = 40000,
  parameter int unsigned SW_W         = 8,
  parameter int unsigned SEL_W        = 5
) (
  input logic             clk,
  input logic             por_n,
  input logic             remote_rst,
  input logic [SW_W-1:0]  mode_sw,
  input logic [SEL_W-1:0] intg_sel,
  input logic             tg_rst_n,
  input logic [SW_W-1:0]  mode_q,
  input logic [SEL_W-1:0] intg_q,
  input logic             load_start,
  input logic             ms_tick
);

  localparam int unsigned PW = (CLK_PER_TICK < 2) ? 1 : $clog2(CLK_PER_TICK);
  localparam logic [PW-1:0] PLAST = PW'(CLK_PER_TICK - 1);

  logic [PW-1:0] ref_phase;
  logic [1:0]    edges_seen;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ref_phase  <= '0;
      edges_seen <= '0;
    end else begin
      ref_phase <= (ref_phase == PLAST) ? '0 : ref_phase + PW'(1);
      if (edges_seen != 2'd3) edges_seen <= edges_seen + 2'd1;
    end
  end

  a_r1_tick_phase: assert property (@(posedge clk) disable iff (!por_n)
    ms_tick == (ref_phase == PLAST));

  a_r1_tick_single: assert property (@(posedge clk) disable iff (!por_n)
    ms_tick |=> !ms_tick);

  a_r3_follow_remote: assert property (@(posedge clk) disable iff (!por_n)
    (edges_seen == 2'd3) |-> (tg_rst_n == !$past(remote_rst, 3)));

  a_r5_no_start_in_hold: assert property (@(posedge clk) disable iff (!por_n)
    !tg_rst_n |-> !load_start);

  a_r6_mode_hold: assert property (@(posedge clk) disable iff (!por_n)
    !load_start |-> ($stable(mode_q) && $stable(intg_q)));

  a_r6_capture: assert property (@(posedge clk) disable iff (!por_n)
    load_start |-> (mode_q == $past(mode_sw) && intg_q == $past(intg_sel)));

  a_r10_start_single: assert property (@(posedge clk) disable iff (!por_n)
    load_start |=> !load_start);

endmodule

bind rst_seq rst_seq_chk #(
  .CLK_PER_TICK (CLK_PER_TICK),
  .SW_W         (SW_W),
  .SEL_W        (SEL_W)
) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .remote_rst (remote_rst),
  .mode_sw    (mode_sw),
  .intg_sel   (intg_sel),
  .tg_rst_n   (tg_rst_n),
  .mode_q     (mode_q),
  .intg_q     (intg_q),
  .load_start (load_start),
  .ms_tick    (ms_tick)
);

// File: tb/sim_rst_seq.sv
`timescale 1ns/1ps
module sim_rst_seq;

  localparam int CPT   = 20;
  localparam int DLY   = 8;
  localparam int DEB   = 2;
  localparam int SW_W  = 8;
  localparam int SEL_W = 5;

  logic             clk = 1'b0;
  logic             por_n = 1'b0;
  logic             board_btn = 1'b0;
  logic             remote_rst = 1'b0;
  logic [SW_W-1:0]  mode_sw = 8'h3C;
  logic [SEL_W-1:0] intg_sel = 5'h07;
  logic             tg_rst_n;
  logic [SW_W-1:0]  mode_q;
  logic [SEL_W-1:0] intg_q;
  logic             load_start;
  logic             ms_tick;

  int n_cmp = 0;
  int n_bad = 0;
  int n_start = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rst_seq #(
    .CLK_PER_TICK (CPT),
    .DELAY_TICKS  (DLY),
    .DEB_TICKS    (DEB),
    .SW_W         (SW_W),
    .SEL_W        (SEL_W)
  ) u0 (
    .clk        (clk),
    .por_n      (por_n),
    .board_btn  (board_btn),
    .remote_rst (remote_rst),
    .mode_sw    (mode_sw),
    .intg_sel   (intg_sel),
    .tg_rst_n   (tg_rst_n),
    .mode_q     (mode_q),
    .intg_q     (intg_q),
    .load_start (load_start),
    .ms_tick    (ms_tick)
  );

  // Behavioural reference: integers for every timer, sampled at posedge.
  int m_div, m_r1, m_r2, m_b1, m_b2, m_db, m_dbn, m_press;
  int m_mode; // 0 held, 1 waiting, 2 running
  int m_wait, m_start, m_tg, m_sw, m_sel;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_div = 0; m_r1 = 0; m_r2 = 0; m_b1 = 0; m_b2 = 0;
      m_db = 0; m_dbn = 0; m_press = 0; m_mode = 1; m_wait = 0;
      m_start = 0; m_tg = 0; m_sw = 0; m_sel = 0;
    end else begin
      int tk, rs, bs, pr;
      tk = (m_div == CPT - 1);
      rs = m_r2; bs = m_b2; pr = m_press;
      m_div = tk ? 0 : m_div + 1;
      m_r2 = m_r1; m_r1 = remote_rst;
      m_b2 = m_b1; m_b1 = board_btn;
      m_press = 0;
      if (bs == m_db) m_dbn = 0;
      else if (tk) begin
        m_dbn++;
        if (m_dbn >= DEB) begin m_db = bs; m_dbn = 0; m_press = bs; end
      end
      m_start = 0;
      m_tg = !rs;
      if (rs) begin m_mode = 0; m_wait = 0; end
      else if (m_mode == 0 || pr) begin m_mode = 1; m_wait = 0; end
      else if (m_mode == 1 && tk) begin
        m_wait++;
        if (m_wait == DLY) begin
          m_mode = 2; m_wait = 0; m_start = 1;
          m_sw = mode_sw; m_sel = intg_sel;
        end
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (por_n && !done) begin
      check("R1 ms_tick", 32'(ms_tick), 32'(m_div == CPT - 1));
      check("R2/R4/R8 load_start", 32'(load_start), 32'(m_start));
      check("R3 tg_rst_n", 32'(tg_rst_n), 32'(m_tg));
      check("R6 mode_q", 32'(mode_q), 32'(m_sw));
      check("R6 intg_q", 32'(intg_q), 32'(m_sel));
      if (load_start === 1'b1) n_start++;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    cycles(3);
    check("R3 reset tg_rst_n", 32'(tg_rst_n), 32'd0);
    check("R2 reset load_start", 32'(load_start), 32'd0);
    check("R1 reset ms_tick", 32'(ms_tick), 32'd0);
    por_n = 1'b1;

    // R2: one start after the power-up wait
    cycles(DLY * CPT + 40);
    check("R2 single start after power-up", 32'(n_start), 32'd1);
    check("R6 power-up capture", 32'(mode_q), 32'h3C);

    // R6: switch change after start is ignored
    mode_sw = 8'hFF; intg_sel = 5'h1F;
    cycles(60);
    check("R6 switches ignored while running", 32'(mode_q), 32'h3C);

    // R3/R5/R4: remote hold and release
    base = n_start;
    remote_rst = 1'b1;
    cycles(10);
    check("R3 tg held low", 32'(tg_rst_n), 32'd0);
    mode_sw = 8'hA5; intg_sel = 5'h13;
    cycles(DLY * CPT + 60);
    check("R5 no start during hold", 32'(n_start - base), 32'd0);
    remote_rst = 1'b0;
    cycles(10);
    check("R3 tg released", 32'(tg_rst_n), 32'd1);
    cycles(DLY * CPT + 40);
    check("R4 start after remote release", 32'(n_start - base), 32'd1);
    check("R6 captured after release", 32'(mode_q), 32'hA5);
    check("R6 intg captured after release", 32'(intg_q), 32'h13);

    // R7: short glitch rejected
    base = n_start;
    board_btn = 1'b1; cycles(10); board_btn = 1'b0;
    cycles(DLY * CPT + 60);
    check("R7 glitch ignored", 32'(n_start - base), 32'd0);

    // R8: second press mid-wait restarts, single start
    base = n_start;
    board_btn = 1'b1; cycles(60); board_btn = 1'b0;
    cycles(50);
    board_btn = 1'b1; cycles(60); board_btn = 1'b0;
    cycles(DLY * CPT + 120);
    check("R8 restart gives one start", 32'(n_start - base), 32'd1);

    // R9: release only, no start
    base = n_start;
    cycles(DLY * CPT + 60);
    check("R9 release gives no start", 32'(n_start - base), 32'd0);

    // R5: press during remote hold ignored
    base = n_start;
    remote_rst = 1'b1;
    cycles(20);
    board_btn = 1'b1; cycles(60); board_btn = 1'b0;
    cycles(120);
    remote_rst = 1'b0;
    cycles(DLY * CPT + 120);
    check("R5 press in hold, one start after release", 32'(n_start - base), 32'd1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog (R1-all) actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule